// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers up to sixty-three active-low interrupt request lines into a pair of 32-bit register banks, called high and low. Each source has an enable bit in a mask register and a flag in a pending register. A fixed scatter table places each source number at a bank and bit position that generally differs from the number itself. Software reaches the block over a small register bus with single-cycle writes and combinational reads. The block drives one interrupt line to the processor.

Most sources are internal and level sensitive. The pending flag of such a source follows the line directly. Seven external request lines can sense either a low level or a falling edge. Sixteen port pins can sense either a falling edge or both edges. The choice is made per source in an edge-select register. A flag raised by an edge stays set until software writes a one to it.

The vector register names the lowest-numbered source that is both pending and enabled. The number sits in the upper six bits, and a value of zero means that nothing is requesting. Source number 0 has no input line. It is reserved, so it never conflicts with the "none" code.

Top module: `intc_top`

Register addresses on `bus_addr`: 0 mask high, 1 mask low, 2 pending high, 3 pending low, 4 edge select, 5 vector. Any other address reads zero.

## Requirements
- R1: After reset, both mask banks and the edge-select register read zero. With every line idle high, both pending banks and the vector read zero and `irq_o` is low.
- R2: The bank is high for sources 1–15 and 32–47, and low for sources 16–31 and 48–63. Bit positions are as follows:
  - sources 1–15 sit at bit 16−s of the high bank;
  - sources 32–47 sit at bit 63−s of the high bank;
  - sources 16–18 sit at bit 18−s of the low bank;
  - sources 19–30 sit at bit 33−s of the low bank;
  - source 31 sits at bit 15 of the low bank;
  - sources 48–63 sit at bit s−32 of the low bank.
- R3: A mask bit of 1 enables its source and 0 disables it. `irq_o` is high exactly when some pending source is enabled. A disabled source still shows in its pending bit.
- R4: Writing 1 to a pending bit clears a flag latched by an edge. Writing 0 has no effect. A level-sensed bit keeps following its line after a write of 1.
- R5: The vector reads the lowest-numbered pending, enabled source in bits 31:26, with bits 25:0 zero. It reads zero when no such source exists.
- R6: An internal source (any source that is neither 19–25 nor 48–63) sets its pending bit while its line is low and clears it when the line returns high, with no clock edge needed.
- R7: For an external source 19–25, the edge-select bit is bit 33−s. A 0 gives low-level sensing. A 1 latches the flag on a falling edge seen at a clock edge, and the flag then survives the line going high.
- R8: For a port source 48–63, the edge-select bit is bit s−32. A 1 latches the flag on falling edges only. A 0 latches it on both falling and rising edges.
- R9: The unused bits of the edge-select register always read 0, so a write of all ones reads back 0xFFFF7F00. Bit 0 of the pending high bank, which belongs to reserved source 0, always reads 0.
- R10: When an edge arrives in the same cycle as a write of 1 to the same pending bit, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_n | input | 63 | Active-low request lines, index equals source number (1 to 63) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Single lines are driven low on internal sources in every mapping region, with source 31 among them. This separates a correct scatter table from one with a shifted or mirrored bit, and the vector readback confirms the number as well. Held levels, single falling edges and rising edges are applied to one external line and one port pin in each edge-select setting. These patterns tell live level sensing from latching, and falling-only sensing from both-edge sensing. Overlapping requests with masks removed one at a time separate lowest-number priority from any other ordering. A write of zeros, a write of ones against a held level, and a clear in the same cycle as an edge each check a different branch of the pending update.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [1:0] {
      K_RSV  = 2'd0,
      K_INT  = 2'd1,
      K_EXT  = 2'd2,
      K_PORT = 2'd3
   } src_kind_e;

   localparam int A_MASK_HI = 0;
   localparam int A_MASK_LO = 1;
   localparam int A_PEND_HI = 2;
   localparam int A_PEND_LO = 3;
   localparam int A_EDGE    = 4;
   localparam int A_VEC     = 5;

   localparam int EXT_FIRST  = 19;
   localparam int EXT_LAST   = 25;
   localparam int PORT_FIRST = 48;
   localparam int PORT_LAST  = 63;

   // 1 selects the low bank
   function automatic bit src_in_lo(input int s);
      return ((s / 16) % 2) == 1;
   endfunction

   function automatic int src_bit(input int s);
      if (s < 16)
         return (s == 0) ? 0 : 16 - s;
      else if (s < 32) begin
         if (s <= 18)
            return 18 - s;
         else if (s == 31)
            return 15;
         else
            return 33 - s;
      end
      else if (s < 48)
         return 63 - s;
      else
         return s - 32;
   endfunction

   function automatic src_kind_e src_kind(input int s);
      if (s == 0)
         return K_RSV;
      else if (s >= EXT_FIRST && s <= EXT_LAST)
         return K_EXT;
      else if (s >= PORT_FIRST && s <= PORT_LAST)
         return K_PORT;
      else
         return K_INT;
   endfunction

   // edge-select bit of a programmable source coincides with its pending bit
   function automatic logic [31:0] es_mask();
      logic [31:0] m;
      m = '0;
      for (int s = 0; s < 64; s++)
         if (src_kind(s) == K_EXT || src_kind(s) == K_PORT)
            m[src_bit(s)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/intc_gather.sv
module intc_gather import intc_pkg::*; #(
   parameter int NSRC   = 64,
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] lo,
   output logic [NSRC-1:0]   src
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam int B = src_bit(i);
      if (src_in_lo(i)) begin : g_lo
         assign src[i] = lo[B];
      end else begin : g_hi
         assign src[i] = hi[B];
      end
   end
endmodule

// File: rtl/intc_scatter.sv
module intc_scatter import intc_pkg::*; #(
   parameter int NSRC   = 64,
   parameter int DATA_W = 32
) (
   input  logic [NSRC-1:0]   src,
   output logic [DATA_W-1:0] hi,
   output logic [DATA_W-1:0] lo
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam int B = src_bit(i);
      if (src_in_lo(i)) begin : g_lo
         assign lo[B] = src[i];
      end else begin : g_hi
         assign hi[B] = src[i];
      end
   end
endmodule

// File: rtl/intc_sense.sv
module intc_sense import intc_pkg::*; #(
   parameter src_kind_e KIND = K_INT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_n,
   input  logic es,
   input  logic clr,
   output logic pend_o,
   output logic lat_o,
   output logic ev_o
);
   localparam bit IS_RSV  = (KIND == K_RSV);
   localparam bit IS_EXT  = (KIND == K_EXT);
   localparam bit IS_PORT = (KIND == K_PORT);

   logic prev_q, lat_q;
   logic edge_mode, both, fall, rise;

   assign edge_mode = (IS_EXT && es) || IS_PORT;
   assign both      = IS_PORT && !es;
   assign fall      = prev_q && !src_n;
   assign rise      = !prev_q && src_n;
   assign ev_o      = edge_mode && (fall || (both && rise));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= src_n;
         if (!edge_mode)
            lat_q <= 1'b0;
         else if (ev_o)
            lat_q <= 1'b1;
         else if (clr)
            lat_q <= 1'b0;
      end
   end

   assign lat_o  = lat_q;
   assign pend_o = IS_RSV ? 1'b0 : (edge_mode ? lat_q : !src_n);
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int NSRC  = 64,
   parameter int IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]  req,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = NSRC - 1; i >= 0; i--)
         if (req[i])
            idx = IDX_W'(i);
   end
endmodule

// File: rtl/intc_top.sv
module intc_top import intc_pkg::*; #(
   parameter int NSRC   = 64,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:1]   src_n,
   output logic              irq_o
);
   localparam int IDX_W   = $clog2(NSRC);
   localparam int VEC_LSB = DATA_W - IDX_W;
   localparam logic [DATA_W-1:0] ES_MASK = es_mask();

   if (NSRC != 64) begin : g_bad_nsrc
      $error("intc_top: the scatter table covers exactly 64 sources");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("intc_top: banks must be 32 bits wide");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("intc_top: address must reach six registers");
   end

   logic [DATA_W-1:0] mask_hi_q, mask_lo_q, edge_q;
   logic [DATA_W-1:0] clr_hi, clr_lo, pend_hi, pend_lo;
   logic [NSRC-1:0]   mask_src, pend_src, lat_src, ev_src, clr_src, act_src, es_src;
   logic [IDX_W-1:0]  vec_idx;
   logic              wr_pend_hi, wr_pend_lo;

   assign wr_pend_hi = bus_we && (bus_addr == ADDR_W'(A_PEND_HI));
   assign wr_pend_lo = bus_we && (bus_addr == ADDR_W'(A_PEND_LO));
   assign clr_hi     = wr_pend_hi ? bus_wdata : '0;
   assign clr_lo     = wr_pend_lo ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_hi_q <= '0;
         mask_lo_q <= '0;
         edge_q    <= '0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(A_MASK_HI)) mask_hi_q <= bus_wdata;
         if (bus_addr == ADDR_W'(A_MASK_LO)) mask_lo_q <= bus_wdata;
         if (bus_addr == ADDR_W'(A_EDGE))    edge_q    <= bus_wdata & ES_MASK;
      end
   end

   intc_gather #(.NSRC(NSRC), .DATA_W(DATA_W)) u_gather_mask (
      .hi(mask_hi_q), .lo(mask_lo_q), .src(mask_src)
   );

   intc_gather #(.NSRC(NSRC), .DATA_W(DATA_W)) u_gather_clr (
      .hi(clr_hi), .lo(clr_lo), .src(clr_src)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_cell
      localparam src_kind_e KD = src_kind(i);
      localparam int        EB = src_bit(i);
      logic line_n;

      if (i == 0) begin : g_rsv
         assign line_n = 1'b1;
      end else begin : g_line
         assign line_n = src_n[i];
      end

      if (KD == K_EXT || KD == K_PORT) begin : g_es
         assign es_src[i] = edge_q[EB];
      end else begin : g_noes
         assign es_src[i] = 1'b0;
      end

      intc_sense #(.KIND(KD)) u_sense (
         .clk   (clk),
         .rst_n (rst_n),
         .src_n (line_n),
         .es    (es_src[i]),
         .clr   (clr_src[i]),
         .pend_o(pend_src[i]),
         .lat_o (lat_src[i]),
         .ev_o  (ev_src[i])
      );
   end

   intc_scatter #(.NSRC(NSRC), .DATA_W(DATA_W)) u_scatter_pend (
      .src(pend_src), .hi(pend_hi), .lo(pend_lo)
   );

   assign act_src = pend_src & mask_src;
   assign irq_o   = |act_src;

   intc_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
      .req(act_src), .idx(vec_idx)
   );

   always_comb begin
      case (bus_addr)
         ADDR_W'(A_MASK_HI): bus_rdata = mask_hi_q;
         ADDR_W'(A_MASK_LO): bus_rdata = mask_lo_q;
         ADDR_W'(A_PEND_HI): bus_rdata = pend_hi;
         ADDR_W'(A_PEND_LO): bus_rdata = pend_lo;
         ADDR_W'(A_EDGE):    bus_rdata = edge_q;
         ADDR_W'(A_VEC):     bus_rdata = {vec_idx, {VEC_LSB{1'b0}}};
         default:            bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk import intc_pkg::*; #(
   parameter int NSRC   = 64,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter int IDX_W  = $clog2(NSRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_o,
   input logic [IDX_W-1:0]  vec_idx,
   input logic [NSRC-1:0]   act_src,
   input logic [NSRC-1:0]   lat_src,
   input logic [NSRC-1:0]   ev_src,
   input logic [NSRC-1:0]   clr_src,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata
);
   localparam int VEC_LSB = DATA_W - IDX_W;

   p_irq_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (vec_idx != '0));

   p_vec_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_idx != '0) |-> act_src[vec_idx]);

   p_vec_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_idx != '0) |-> ((act_src & ((NSRC'(1) << vec_idx) - NSRC'(1))) == '0));

   p_vec_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(A_VEC)) |-> (bus_rdata[VEC_LSB-1:0] == '0));

   for (genvar i = PORT_FIRST; i <= PORT_LAST; i++) begin : g_port
      p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (lat_src[i] && !clr_src[i]) |=> lat_src[i]);

      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ev_src[i] |=> lat_src[i]);
   end
endmodule

bind intc_top intc_chk #(
   .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_o    (irq_o),
   .vec_idx  (vec_idx),
   .act_src  (act_src),
   .lat_src  (lat_src),
   .ev_src   (ev_src),
   .clr_src  (clr_src),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata)
);

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:1] src_n = '1;
   logic        irq_o;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   intc_top i_intc_top (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_n(src_n), .irq_o(irq_o)
   );

   // bank: 1 = low; from R2
   function automatic bit m_lo(input int s);
      return (s >= 16 && s < 32) || s >= 48;
   endfunction

   function automatic int m_bit(input int s);
      int b;
      case (1'b1)
         (s >= 1  && s <= 15): b = 16 - s;
         (s >= 16 && s <= 18): b = 18 - s;
         (s == 31):            b = 15;
         (s >= 19 && s <= 30): b = 33 - s;
         (s >= 32 && s <= 47): b = 63 - s;
         default:              b = s - 32;
      endcase
      return b;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 3'(a);
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] vecw(input int s);
      return {6'(s), 26'd0};
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd(0, v); check("R1 mask high", v, 0);
      rd(1, v); check("R1 mask low", v, 0);
      rd(4, v); check("R1 edge select", v, 0);
      rd(2, v); check("R1 pending high", v, 0);
      rd(3, v); check("R1 pending low", v, 0);
      rd(5, v); check("R1 vector", v, 0);
      check("R1 irq", {31'd0, irq_o}, 0);
   endtask

   task automatic t_mapping();
      int list [10] = '{1, 7, 15, 16, 18, 26, 30, 31, 33, 47};
      logic [31:0] v;
      wr(0, 32'hFFFF_FFFF);
      wr(1, 32'hFFFF_FFFF);
      foreach (list[k]) begin
         int s = list[k];
         src_n[s] = 1'b0;
         rd(m_lo(s) ? 3 : 2, v);
         check($sformatf("R2 R6 source %0d own bank", s), v, 32'd1 << m_bit(s));
         rd(m_lo(s) ? 2 : 3, v);
         check($sformatf("R2 source %0d other bank", s), v, 0);
         rd(5, v);
         check($sformatf("R5 vector source %0d", s), v, vecw(s));
         src_n[s] = 1'b1;
         rd(m_lo(s) ? 3 : 2, v);
         check($sformatf("R6 source %0d released", s), v, 0);
         tick();
      end
   endtask

   task automatic t_mask();
      logic [31:0] v;
      src_n[5] = 1'b0;
      wr(0, ~(32'd1 << 11));
      rd(5, v); check("R3 masked vector", v, 0);
      check("R3 masked irq", {31'd0, irq_o}, 0);
      rd(2, v); check("R3 masked still pending", v, 32'd1 << 11);
      wr(0, 32'd1 << 11);
      wr(1, 32'd0);
      check("R3 single enable irq", {31'd0, irq_o}, 1);
      rd(5, v); check("R3 single enable vector", v, vecw(5));
      wr(2, 32'hFFFF_FFFF);
      rd(2, v); check("R4 level survives clear", v, 32'd1 << 11);
      src_n[5] = 1'b1;
      wr(0, 32'hFFFF_FFFF);
      wr(1, 32'hFFFF_FFFF);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      src_n[40] = 1'b0; src_n[9] = 1'b0; src_n[20] = 1'b0;
      rd(5, v); check("R5 lowest of 9/20/40", v, vecw(9));
      wr(0, ~(32'd1 << 7));
      rd(5, v); check("R5 after masking 9", v, vecw(20));
      wr(1, 32'd0);
      rd(5, v); check("R5 after masking 20", v, vecw(40));
      src_n[40] = 1'b1; src_n[9] = 1'b1; src_n[20] = 1'b1;
      rd(5, v); check("R5 none left", v, 0);
      wr(0, 32'hFFFF_FFFF);
      wr(1, 32'hFFFF_FFFF);
   endtask

   task automatic t_ext();
      logic [31:0] v;
      src_n[22] = 1'b0;
      rd(3, v); check("R7 level mode low", v, 32'd1 << 11);
      src_n[22] = 1'b1;
      rd(3, v); check("R7 level mode released", v, 0);
      wr(4, 32'd1 << 11);
      src_n[22] = 1'b0;
      tick();
      rd(3, v); check("R7 falling edge latched", v, 32'd1 << 11);
      src_n[22] = 1'b1;
      tick();
      rd(3, v); check("R7 latch survives high line", v, 32'd1 << 11);
      wr(3, 32'd0);
      rd(3, v); check("R4 write zero ignored", v, 32'd1 << 11);
      wr(3, 32'd1 << 11);
      rd(3, v); check("R4 write one clears", v, 0);
      wr(4, 32'd0);
   endtask

   task automatic t_port();
      logic [31:0] v;
      src_n[50] = 1'b0;
      tick();
      rd(3, v); check("R8 both-edge mode falling", v, 32'd1 << 18);
      rd(5, v); check("R8 vector port 50", v, vecw(50));
      wr(3, 32'd1 << 18);
      rd(3, v); check("R8 cleared while low", v, 0);
      src_n[50] = 1'b1;
      tick();
      rd(3, v); check("R8 both-edge mode rising", v, 32'd1 << 18);
      wr(3, 32'd1 << 18);
      wr(4, 32'd1 << 18);
      src_n[50] = 1'b0;
      tick();
      rd(3, v); check("R8 falling-only mode falling", v, 32'd1 << 18);
      wr(3, 32'd1 << 18);
      src_n[50] = 1'b1;
      tick();
      rd(3, v); check("R8 falling-only mode rising ignored", v, 0);
      wr(4, 32'd0);
   endtask

   task automatic t_setwins();
      logic [31:0] v;
      wr(4, 32'd1 << 23);
      @(negedge clk);
      src_n[55] = 1'b0;
      bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'd1 << 23;
      @(negedge clk);
      bus_we = 1'b0;
      rd(3, v); check("R10 edge beats same-cycle clear", v, 32'd1 << 23);
      wr(3, 32'hFFFF_FFFF);
      src_n[55] = 1'b1;
      tick();
      rd(3, v); check("R10 cleared afterwards", v, 0);
      wr(4, 32'd0);
   endtask

   task automatic t_unimpl();
      logic [31:0] v;
      wr(4, 32'hFFFF_FFFF);
      rd(4, v); check("R9 edge select readback", v, 32'hFFFF_7F00);
      wr(4, 32'd0);
      rd(2, v); check("R9 reserved bit zero", v & 32'd1, 0);
      rd(6, v); check("R9 unused address", v, 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mapping();
      t_mask();
      t_priority();
      t_ext();
      t_port();
      t_setwins();
      t_unimpl();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule